// File: doc/BRIEF.md
# CAN Bit Timing Prescaler

This block produces the time base of a CAN protocol engine. A programmable
divider turns the system clock into time-quantum ticks. A quantum counter
splits each nominal bit into a synchronisation quantum, a first time segment
(propagation plus phase 1) and a second time segment (phase 2). The block
emits a one-cycle strobe at the sample point and another at the end of every
bit. Recessive-to-dominant edges on the receive line move the bit boundaries
by a bounded amount, so the local bit clock follows a transmitter whose
oscillator drifts.

Three registers configure it. A control byte holds an init bit (bit 0) and a
configuration-change enable bit (bit 6). A timing word holds the low divider
bits, the resynchronisation jump width and both segment lengths. A small
extension register holds the high divider bits. Every field stores its value
minus one. The timing word and the extension can only be written while init
and configuration-change enable are both set. While init is set the time base
is stopped.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the control byte reads 0x01, the timing word reads 0x2301, the extension reads 0, and tq_tick, sample_pt and bit_end are low.
- R2: A control write always takes effect. A write to the timing word or the extension takes effect only if control bit 0 and control bit 6 are both 1 in the cycle of the write. Otherwise the write is ignored and the readback does not change.
- R3: While control bit 0 is 1, tq_tick, sample_pt and bit_end stay low and the counters are held at their start values.
- R4: tq_tick is a one-cycle pulse that repeats every P+1 clocks. P is the 10-bit value {ext[3:0], btr[5:0]}, so P+1 ranges from 1 to 1024.
- R5: A nominal bit lasts 1 + (T1+1) + (T2+1) quanta, with T1 = btr[11:8] and T2 = btr[14:12]. A T1 field of 0 is treated as 1, so the first segment is never shorter than 2 quanta. bit_end pulses once per bit.
- R6: sample_pt pulses (T1+2) quanta after bit_end, that is, at the close of the first time segment.
- R7: rx_in is 1 when recessive. A falling edge belongs to quantum q, where q is the quantum in progress one clock after the clock edge that first samples the low level. If 1 <= q <= the sample quantum index, the sample point and the bit end both move later by min(q, S+1) quanta, with S = btr[7:6].
- R8: An edge in the second segment (q above the sample index) shortens the bit. The last quantum index becomes max(q, E-(S+1)), where E is the current last index.
- R9: An edge in the synchronisation quantum (q = 0) is ignored. Within one bit only the first edge with q > 0 is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control write data (bit 0 init, bit 6 configuration-change enable) |
| btr_we | input | 1 | Timing word write strobe |
| btr_wdata | input | 15 | Timing word write data |
| ext_we | input | 1 | Divider extension write strobe |
| ext_wdata | input | 4 | Divider extension write data |
| rx_in | input | 1 | Receive line level, 1 = recessive |
| ctl_q | output | 8 | Control byte readback |
| btr_q | output | 15 | Timing word readback |
| ext_q | output | 4 | Divider extension readback |
| tq_tick | output | 1 | Time-quantum tick |
| sample_pt | output | 1 | Sample point strobe |
| bit_end | output | 1 | End-of-bit strobe |

## Verification
The boundary move from a bus edge and the quantum tick that advances the counter can fall in the same clock. At a divider of 1 this happens on every edge, and it matters most when a shortening edge lands on the very quantum that becomes the new last one, so the bit has to close in that same cycle. The bench runs the divider at 1 and places single-clock dominant pulses at chosen quanta in both segments, in the sync quantum, and twice in one bit. It judges each case by the distance in clocks between successive bit_end pulses, compared with a value computed from R7 to R9.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_LO_W = 6;
  localparam int BRP_HI_W = 4;
  localparam int SJW_W    = 2;
  localparam int TS1_W    = 4;
  localparam int TS2_W    = 3;
  localparam int CTL_W    = 8;

  localparam int BRP_W    = BRP_LO_W + BRP_HI_W;
  localparam int SJW_LSB  = BRP_LO_W;
  localparam int TS1_LSB  = SJW_LSB + SJW_W;
  localparam int TS2_LSB  = TS1_LSB + TS1_W;
  localparam int BTR_W    = TS2_LSB + TS2_W;

  localparam int CTL_INIT_BIT = 0;
  localparam int CTL_CCE_BIT  = 6;

  // largest last-quantum index: stretched first segment plus longest phase 2
  localparam int QC_MAX = (1 << TS1_W) + (1 << SJW_W) + (1 << TS2_W) + 1;
  localparam int QC_W   = $clog2(QC_MAX + 1);

  typedef logic [QC_W-1:0] qidx_t;
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import can_bt_pkg::*;
#(
  parameter logic [CTL_W-1:0]    CTL_RST = 8'h01,
  parameter logic [BTR_W-1:0]    BTR_RST = 15'h2301,
  parameter logic [BRP_HI_W-1:0] EXT_RST = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_we,
  input  logic [CTL_W-1:0]    ctl_wdata,
  input  logic                btr_we,
  input  logic [BTR_W-1:0]    btr_wdata,
  input  logic                ext_we,
  input  logic [BRP_HI_W-1:0] ext_wdata,
  output logic [CTL_W-1:0]    ctl_q,
  output logic [BTR_W-1:0]    btr_q,
  output logic [BRP_HI_W-1:0] ext_q
);
  logic unlock;
  assign unlock = ctl_q[CTL_INIT_BIT] & ctl_q[CTL_CCE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RST;
      btr_q <= BTR_RST;
      ext_q <= EXT_RST;
    end else begin
      if (ctl_we)           ctl_q <= ctl_wdata;
      if (btr_we && unlock) btr_q <= btr_wdata;
      if (ext_we && unlock) ext_q <= ext_wdata;
    end
  end

  // R2: timing storage frozen whenever the unlock pair is not set
  a_r2_locked: assert property (@(posedge clk) disable iff (rst)
    !(ctl_q[CTL_INIT_BIT] && ctl_q[CTL_CCE_BIT]) |=> ($stable(btr_q) && $stable(ext_q)));
endmodule

// File: rtl/tq_prescaler.sv
module tq_prescaler #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tq_tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      cnt     <= '0;
      tq_tick <= 1'b0;
    end else if (cnt == div_m1) begin
      cnt     <= '0;
      tq_tick <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      tq_tick <= 1'b0;
    end
  end

  // R4: with a divider above one the tick lasts a single clock
  a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
    (tq_tick && div_m1 != '0) |=> !tq_tick);

  // R3: no ticks while halted
  a_r3_tick_quiet: assert property (@(posedge clk) disable iff (rst)
    halt |=> !tq_tick);
endmodule

// File: rtl/rx_edge_det.sv
module rx_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_fall
);
  logic rx_s, rx_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s <= 1'b1;
      rx_p <= 1'b1;
    end else begin
      rx_s <= rx_in;
      rx_p <= rx_s;
    end
  end

  assign rx_fall = rx_p & ~rx_s;

  // R7: an edge is flagged one clock after the low level is first sampled
  a_r7_fall_seen: assert property (@(posedge clk) disable iff (rst)
    rx_fall |-> (!$past(rx_in) && $past(rx_in, 2)));
endmodule

// File: rtl/bit_segmenter.sv
module bit_segmenter
  import can_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic             tq_tick,
  input  logic [SJW_W-1:0] sjw,
  input  logic [TS1_W-1:0] ts1,
  input  logic [TS2_W-1:0] ts2,
  input  logic             rx_fall,
  output logic             sample_pt,
  output logic             bit_end
);
  qidx_t qcnt, sp_idx, end_idx;
  qidx_t sp_nom, end_nom, sjw_len, lag, sp_n, end_n;
  logic [TS1_W-1:0] ts1_eff;
  logic resynced, edge_ok, in_seg1;

  always_comb begin
    ts1_eff = (ts1 == '0) ? TS1_W'(1) : ts1;
    sp_nom  = qidx_t'(ts1_eff) + qidx_t'(1);
    end_nom = sp_nom + qidx_t'(ts2) + qidx_t'(1);
    sjw_len = qidx_t'(sjw) + qidx_t'(1);
    edge_ok = rx_fall && !resynced && (qcnt != '0);
    in_seg1 = (qcnt <= sp_idx);
    lag     = (qcnt < sjw_len) ? qcnt : sjw_len;
    sp_n    = sp_idx;
    end_n   = end_idx;
    if (edge_ok) begin
      if (in_seg1) begin
        sp_n  = sp_idx + lag;
        end_n = end_idx + lag;
      end else begin
        end_n = (end_idx >= qcnt + sjw_len) ? (end_idx - sjw_len) : qcnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      qcnt      <= '0;
      sp_idx    <= sp_nom;
      end_idx   <= end_nom;
      resynced  <= 1'b0;
      sample_pt <= 1'b0;
      bit_end   <= 1'b0;
    end else begin
      sample_pt <= 1'b0;
      bit_end   <= 1'b0;
      sp_idx    <= sp_n;
      end_idx   <= end_n;
      resynced  <= resynced | edge_ok;
      if (tq_tick) begin
        if (qcnt == end_n) begin
          qcnt     <= '0;
          bit_end  <= 1'b1;
          sp_idx   <= sp_nom;
          end_idx  <= end_nom;
          resynced <= 1'b0;
        end else begin
          qcnt <= qcnt + qidx_t'(1);
          if (qcnt == sp_n) sample_pt <= 1'b1;
        end
      end
    end
  end

  // R6: the sample strobe and the bit-end strobe never coincide
  a_r6_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(sample_pt && bit_end));

  // R5: a bit closes only on a quantum tick
  a_r5_end_on_tick: assert property (@(posedge clk) disable iff (rst)
    bit_end |-> $past(tq_tick));

  // R3: strobes silent while halted
  a_r3_strobe_quiet: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!sample_pt && !bit_end));

  // R8: the quantum counter never passes the (possibly shortened) last index
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    qcnt <= end_idx);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_we,
  input  logic [CTL_W-1:0]    ctl_wdata,
  input  logic                btr_we,
  input  logic [BTR_W-1:0]    btr_wdata,
  input  logic                ext_we,
  input  logic [BRP_HI_W-1:0] ext_wdata,
  input  logic                rx_in,
  output logic [CTL_W-1:0]    ctl_q,
  output logic [BTR_W-1:0]    btr_q,
  output logic [BRP_HI_W-1:0] ext_q,
  output logic                tq_tick,
  output logic                sample_pt,
  output logic                bit_end
);
  logic             halt, rx_fall;
  logic [BRP_W-1:0] div_m1;

  cfg_regs u_cfg (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .btr_we(btr_we), .btr_wdata(btr_wdata),
    .ext_we(ext_we), .ext_wdata(ext_wdata),
    .ctl_q(ctl_q), .btr_q(btr_q), .ext_q(ext_q)
  );

  assign halt   = ctl_q[CTL_INIT_BIT];
  assign div_m1 = {ext_q, btr_q[BRP_LO_W-1:0]};

  tq_prescaler #(.DIV_W(BRP_W)) u_pre (
    .clk(clk), .rst(rst), .halt(halt), .div_m1(div_m1), .tq_tick(tq_tick)
  );

  rx_edge_det u_edge (
    .clk(clk), .rst(rst), .rx_in(rx_in), .rx_fall(rx_fall)
  );

  bit_segmenter u_seg (
    .clk(clk), .rst(rst), .halt(halt), .tq_tick(tq_tick),
    .sjw(btr_q[TS1_LSB-1:SJW_LSB]),
    .ts1(btr_q[TS2_LSB-1:TS1_LSB]),
    .ts2(btr_q[BTR_W-1:TS2_LSB]),
    .rx_fall(rx_fall),
    .sample_pt(sample_pt), .bit_end(bit_end)
  );
endmodule

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0, btr_we = 1'b0, ext_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [14:0] btr_wdata = '0;
  logic [3:0]  ext_wdata = '0;
  logic rx_in = 1'b1;
  logic [7:0]  ctl_q;
  logic [14:0] btr_q;
  logic [3:0]  ext_q;
  logic tq_tick, sample_pt, bit_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .btr_we(btr_we), .btr_wdata(btr_wdata),
    .ext_we(ext_we), .ext_wdata(ext_wdata),
    .rx_in(rx_in),
    .ctl_q(ctl_q), .btr_q(btr_q), .ext_q(ext_q),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wdata = v; ctl_we = 1'b1; @(negedge clk); ctl_we = 1'b0;
  endtask
  task automatic wr_btr(input logic [14:0] v);
    btr_wdata = v; btr_we = 1'b1; @(negedge clk); btr_we = 1'b0;
  endtask
  task automatic wr_ext(input logic [3:0] v);
    ext_wdata = v; ext_we = 1'b1; @(negedge clk); ext_we = 1'b0;
  endtask

  function automatic int t1_eff(input int t1);
    return (t1 == 0) ? 1 : t1;
  endfunction
  function automatic int bit_quanta(input int t1, input int t2);
    return 1 + (t1_eff(t1) + 1) + (t2 + 1);
  endfunction
  // R7/R8/R9: length in quanta of a bit that sees edges at quanta qa then qb
  function automatic int resync_len(input int t1, input int t2, input int sj, input int qa, input int qb);
    int sp, last, q, jump;
    sp = t1_eff(t1) + 1;
    last = sp + t2 + 1;
    jump = sj + 1;
    q = (qa > 0) ? qa : qb;
    if (q <= 0) return last + 1;
    if (q <= sp) return last + 1 + ((q < jump) ? q : jump);
    return (((last - jump) > q) ? (last - jump) : q) + 1;
  endfunction

  function automatic logic [14:0] pack_btr(input int p, input int t1, input int t2, input int sj);
    return {3'(t2), 4'(t1), 2'(sj), 6'(p % 64)};
  endfunction

  task automatic configure(input int p, input int t1, input int t2, input int sj);
    wr_ctl(8'h41);
    wr_btr(pack_btr(p, t1, t2, sj));
    wr_ext(4'(p / 64));
    wr_ctl(8'h00);
  endtask

  task automatic quiet_window(input string req, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tq_tick || sample_pt || bit_end) seen++;
    end
    check(req, "strobes while init set", seen, 0);
  endtask

  task automatic run_timing(input int p, input int t1, input int t2, input int sj);
    int cnt;
    configure(p, t1, t2, sj);
    while (!tq_tick) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tq_tick);
    check("R4", "tick period", cnt, p + 1);
    while (!bit_end) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!sample_pt);
    check("R6", "bit_end to sample_pt", cnt, (t1_eff(t1) + 2) * (p + 1));
    while (!bit_end) begin @(negedge clk); cnt++; end
    check("R5", "bit length", cnt, bit_quanta(t1, t2) * (p + 1));
    wr_ctl(8'h41);
  endtask

  // divider of 1: one quantum per clock; reference bit_end at cycle 0
  task automatic resync_trial(input string req, input int t1, input int t2, input int sj,
                              input int qa, input int qb);
    int nom, t_first, t_second, c;
    nom = bit_quanta(t1, t2);
    rx_in = 1'b1;
    while (!bit_end) @(negedge clk);
    t_first = -1; t_second = -1; c = 0;
    while (t_second < 0 && c < 200) begin
      if (c > 0 && bit_end) begin
        if (t_first < 0) t_first = c; else t_second = c;
      end
      rx_in = !((c == nom + qa - 1) || (qb > 0 && c == nom + qb - 1));
      @(negedge clk);
      c++;
    end
    rx_in = 1'b1;
    check(req, "undisturbed bit", t_first, nom);
    check(req, "resynced bit length", t_second - t_first, resync_len(t1, t2, sj, qa, qb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "ctl_q", int'(ctl_q), 'h01);
    check("R1", "btr_q", int'(btr_q), 'h2301);
    check("R1", "ext_q", int'(ext_q), 0);
    check("R1", "strobes", int'(tq_tick) + int'(sample_pt) + int'(bit_end), 0);
    quiet_window("R3", 40);

    // R2 write protection
    wr_btr(15'h1234);
    check("R2", "btr write with cce=0", int'(btr_q), 'h2301);
    wr_ext(4'h5);
    check("R2", "ext write with cce=0", int'(ext_q), 0);
    wr_ctl(8'h40);
    check("R2", "ctl write always", int'(ctl_q), 'h40);
    wr_btr(15'h1234);
    check("R2", "btr write with init=0", int'(btr_q), 'h2301);
    wr_ctl(8'h41);
    wr_btr(15'h1234);
    check("R2", "btr write unlocked", int'(btr_q), 'h1234);
    wr_ext(4'h9);
    check("R2", "ext write unlocked", int'(ext_q), 9);
    wr_ctl(8'h00);
    wr_btr(15'h0777);
    check("R2", "btr write while running", int'(btr_q), 'h1234);

    // R3 stopping halts everything
    wr_ctl(8'h01);
    @(negedge clk);
    quiet_window("R3", 40);

    // R4 R5 R6 directed corners
    run_timing(0, 0, 0, 0);
    run_timing(1023, 1, 0, 0);
    run_timing(3, 15, 7, 3);
    // random configurations
    for (int k = 0; k < 8; k++) begin
      int p, t1, t2, sj;
      p  = int'($urandom_range(31, 0)) + 64 * int'($urandom_range(1, 0));
      t1 = int'($urandom_range(15, 0));
      t2 = int'($urandom_range(7, 0));
      sj = int'($urandom_range(3, 0));
      run_timing(p, t1, t2, sj);
    end

    // R7 R8 R9 resynchronisation, divider of 1
    configure(0, 5, 4, 1);
    resync_trial("R7", 5, 4, 1, 1, 0);
    resync_trial("R7", 5, 4, 1, 3, 0);
    resync_trial("R7", 5, 4, 1, 6, 0);
    resync_trial("R8", 5, 4, 1, 8, 0);
    resync_trial("R8", 5, 4, 1, 10, 0);
    resync_trial("R8", 5, 4, 1, 11, 0);
    resync_trial("R9", 5, 4, 1, 0, 0);
    resync_trial("R9", 5, 4, 1, 2, 4);
    resync_trial("R9", 5, 4, 1, 0, 3);
    wr_ctl(8'h41);
    configure(0, 5, 4, 3);
    resync_trial("R7", 5, 4, 3, 3, 0);
    resync_trial("R8", 5, 4, 3, 8, 0);
    for (int k = 0; k < 6; k++) begin
      int q;
      q = int'($urandom_range(10, 1));
      resync_trial((q <= 6) ? "R7" : "R8", 5, 4, 3, q, 0);
    end
    wr_ctl(8'h41);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule